// File: doc/BRIEF.md
# North Bridge Control Register File

This block is the bank of control and status words that a CPU-to-PCI host bridge exposes to software. It holds twenty-eight 32-bit words: bridge configuration, memory and I/O timing setup, general-purpose I/O data and enables, interrupt routing, mailboxes and SDRAM sizing. The stored values feed the logic around the bridge, which is not part of this block. Software reaches the bank over a simple word-wide port. Each access carries a 7-bit byte offset, and the word index is that offset with its two low bits dropped.

Interrupt enables are never written directly. A write-one-to-set alias ORs bits into the enable word, and a write-one-to-clear alias removes them. The interrupt status word follows an external status input on every clock and cannot be written. The general configuration word carries a self-reset bit. When a write turns that bit from 0 to 1, the block issues a one-cycle system reset request. Every register takes a fixed value at reset.

Top module: `nb_ctrl_regs`

## Requirements
- R1: The word index is `wr_off[6:2]` for writes and `rd_off[6:2]` for reads, and the two low offset bits are ignored. Indices 0 to 27 (offsets 0x00 to 0x6C) are mapped. `rd_data` shows the addressed word combinationally in the same cycle.
- R2: After reset the words hold these values: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other word is 0, and `sys_reset_req` is 0.
- R3: When `wr_en` is high at a rising edge and the offset is an ordinary mapped word, the full 32-bit `wr_data` is stored and reads back from the next cycle on.
- R4: A write to 0x30 stores `wr_data` at 0x30 and ORs it into the enable word at 0x38.
- R5: A write to 0x34 stores `wr_data` at 0x34 and clears every bit of 0x38 that is set in `wr_data`.
- R6: A write to 0x38 has no effect. The enable word changes only through 0x30 and 0x34.
- R7: The status word at 0x3C takes the value of `irq_status_in` at every rising edge. A write to 0x3C has no effect.
- R8: A write to 0x04 with bit 2 (self-reset) at 1, while the stored bit 2 is 0, stores the value and drives `sys_reset_req` high for exactly the one cycle after that edge.
- R9: A write to 0x04 stores the value without a reset request when bit 2 was already 1 or the written bit 2 is 0.
- R10: Offsets 0x70 to 0x7F read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per asserted cycle |
| wr_off | input | 7 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_off | input | 7 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| irq_status_in | input | 32 | Live interrupt status, captured each cycle |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The embedded assertions check on every cycle that the enable word changes only through the set and clear aliases, with the correct OR or AND-NOT result. They also check that the status word follows its input one cycle late, and that the reset request lasts one cycle and only ever follows a 0-to-1 write of the self-reset bit. The reset values, the full-word read-back of ordinary registers, the aliasing of offsets with non-zero low bits, and the zero reads and dropped writes of unmapped offsets can only be shown by the bench. It does this through directed scenarios and a long random write and read sequence compared against its own register model.

// File: rtl/nb_ctrl_regs.sv
module nb_ctrl_regs #(
  parameter int DW      = 32,
  parameter int OW      = 7,
  parameter int NREG    = 28,
  parameter int ICFG    = 1,
  parameter int ISET    = 12,
  parameter int ICLR    = 13,
  parameter int IEN     = 14,
  parameter int ISR     = 15,
  parameter int RST_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic [OW-1:0] rd_off,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] irq_status_in,
  output logic          sys_reset_req
);
  localparam int IW = OW - 2;

  logic [DW-1:0] regs [NREG];

  wire [IW-1:0] widx   = wr_off[OW-1:2];
  wire [IW-1:0] ridx   = rd_off[OW-1:2];
  wire          w_map  = {1'b0, widx} < (IW+1)'(NREG);
  wire          r_map  = {1'b0, ridx} < (IW+1)'(NREG);
  wire          w_set  = wr_en && widx == IW'(ISET);
  wire          w_clr  = wr_en && widx == IW'(ICLR);
  wire          w_cfg  = wr_en && widx == IW'(ICFG);
  wire          w_ro   = widx == IW'(IEN) || widx == IW'(ISR);
  wire          kick   = w_cfg && wr_data[RST_BIT] && !regs[ICFG][RST_BIT];

  function automatic logic [DW-1:0] init_val(input int i);
    case (i)
      0:       return DW'(32'h0000_0C40);
      1:       return DW'(32'h0000_1384);
      2:       return DW'(32'h2BFF_8010);
      3:       return DW'(32'h255E_0091);
      4:       return DW'(32'h0000_6140);
      7:       return DW'(32'h0000_01FF);
      8:       return DW'(32'h0000_01FF);
      26:      return DW'(32'h0000_0008);
      27:      return DW'(32'h1000_0000);
      default: return '0;
    endcase
  endfunction

  assign rd_data = r_map ? regs[ridx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= init_val(i);
      sys_reset_req <= 1'b0;
    end else begin
      sys_reset_req <= kick;
      regs[ISR]     <= irq_status_in;
      if (w_set) begin
        regs[ISET] <= wr_data;
        regs[IEN]  <= regs[IEN] | wr_data;
      end else if (w_clr) begin
        regs[ICLR] <= wr_data;
        regs[IEN]  <= regs[IEN] & ~wr_data;
      end else if (wr_en && w_map && !w_ro) begin
        regs[widx] <= wr_data;
      end
    end
  end

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> regs[IEN] == ($past(regs[IEN]) | $past(wr_data)));

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> regs[IEN] == ($past(regs[IEN]) & ~$past(wr_data)));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_set || w_clr) |=> $stable(regs[IEN]));

  // R7
  isr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> regs[ISR] == $past(irq_status_in));

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);

  // R9
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(regs[ICFG][RST_BIT]) == 1'b0 && regs[ICFG][RST_BIT]);
endmodule

// File: tb/nb_ctrl_regs_tb.sv
module nb_ctrl_regs_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_off = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_off = '0;
  logic [31:0] rd_data;
  logic [31:0] irq_in = '0;
  logic        sys_reset_req;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] mdl [28];
  logic        exp_pulse = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  nb_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .rd_off(rd_off), .rd_data(rd_data), .irq_status_in(irq_in),
    .sys_reset_req(sys_reset_req)
  );

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      0: return 32'h0000_0C40;  1: return 32'h0000_1384;
      2: return 32'h2BFF_8010;  3: return 32'h255E_0091;
      4: return 32'h0000_6140;  7: return 32'h0000_01FF;
      8: return 32'h0000_01FF; 26: return 32'h0000_0008;
      27: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [6:0] off);
    int i;
    i = int'(off[6:2]);
    return (i < 28) ? mdl[i] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic tick();
    int i;
    @(posedge clk);
    exp_pulse = 1'b0;
    if (wr_en) begin
      i = int'(wr_off[6:2]);
      if (i == 1 && wr_data[2] && !mdl[1][2]) exp_pulse = 1'b1;
      if (i == 12) begin mdl[12] = wr_data; mdl[14] = mdl[14] | wr_data; end
      else if (i == 13) begin mdl[13] = wr_data; mdl[14] = mdl[14] & ~wr_data; end
      else if (i < 28 && i != 14 && i != 15) mdl[i] = wr_data;
    end
    mdl[15] = irq_in;
    @(negedge clk);
    check("R8/R9 pulse", {31'b0, sys_reset_req}, {31'b0, exp_pulse});
  endtask

  task automatic wr(input logic [6:0] off, input logic [31:0] d);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [6:0] off);
    rd_off = off;
    #1;
    check(req, rd_data, exp_rd(off));
  endtask

  initial begin
    #(CLK_NS * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 28; i++) mdl[i] = rst_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state, R10 unmapped reads zero
    check("R2 req", {31'b0, sys_reset_req}, 32'h0);
    for (int o = 0; o < 128; o += 4) rd("R2/R10 reset read", 7'(o));
    tick();
    // R3 ordinary words, R1 low bits ignored
    wr(7'h40, 32'hDEAD_BEEF); rd("R3 mailbox", 7'h40);
    wr(7'h4B, 32'h1234_5678); rd("R1 alias low bits", 7'h48); rd("R1 alias read", 7'h4A);
    wr(7'h6C, 32'hFFFF_FFFF); rd("R3 last word", 7'h6C);
    // R4 / R5
    wr(7'h30, 32'h0000_00F0); rd("R4 enable", 7'h38); rd("R4 set word", 7'h30);
    wr(7'h30, 32'h8000_0001); rd("R4 enable or", 7'h38);
    wr(7'h34, 32'h0000_0030); rd("R5 enable", 7'h38); rd("R5 clr word", 7'h34);
    // R6
    wr(7'h38, 32'hFFFF_FFFF); rd("R6 enable ignored", 7'h38);
    // R7
    irq_in = 32'hA5A5_0F0F; tick(); rd("R7 status", 7'h3C);
    wr(7'h3C, 32'h0); rd("R7 status write ignored", 7'h3C);
    // R8 / R9
    wr(7'h04, 32'h0000_1384); rd("R9 already set", 7'h04);
    wr(7'h04, 32'h0000_0001); rd("R9 cleared", 7'h04);
    wr(7'h04, 32'h0000_0005); rd("R8 stored", 7'h04);
    wr(7'h04, 32'h0000_0004);
    // R10 writes ignored
    wr(7'h70, 32'hFFFF_FFFF); rd("R10 unmapped", 7'h70);
    for (int o = 0; o < 112; o += 4) rd("R10 no side effect", 7'(o));
    // random mix
    for (int n = 0; n < 600; n++) begin
      irq_in = $urandom;
      wr(7'($urandom % 128), $urandom);
      rd("R3/R1 random", 7'($urandom % 128));
      rd("R4/R5 random enable", 7'h38);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule